// File: doc/BRIEF.md
# Multiprocessor UART Receive Filter

This block is the receive half of an asynchronous serial port that can run on a line shared by one master and several slaves. It watches a serial input line and recovers each frame. It delivers the data byte and a ninth status bit, and it raises a receive interrupt request that stays set until it is cleared. A mode input selects the frame format. In the short format a frame carries eight data bits. In the long format it carries eight data bits plus a ninth bit. An external tick at sixteen times the bit rate paces all sampling.

A filter enable input gates the interrupt. In the long format, the ninth bit tells an address frame (ninth bit 1) from a data frame (ninth bit 0). With the filter on, only address frames raise the interrupt, so a slave that has not been addressed never sees the data bytes meant for another slave. Once a slave recognises its own address, its software turns the filter off and then takes the data frames that follow. In the short format, the same enable makes the interrupt depend on the stop bit being sampled high.

The line first passes through two synchronising flops. A start is taken on a falling edge and confirmed at mid-bit. Each bit value is the majority of three samples around the bit centre.

Top module: `mpuart_rx_filter`

## Requirements
- R1: After reset, rxData is 0x00, rxNinth is 0 and rxIrq is 0.
- R2: Data bits arrive least significant bit first, straight after the start bit. rxData shows the recovered byte once the frame completes and does not change between completions.
- R3: With nineBitMode=1, the bit that follows the eighth data bit is latched into rxNinth. With nineBitMode=0, rxNinth takes the sampled stop bit value.
- R4: With filterEn=0, every completed frame sets rxIrq in both formats, whatever value the stop bit has.
- R5: With nineBitMode=1 and filterEn=1, a frame sets rxIrq only when its ninth bit is 1. A frame whose ninth bit is 0 leaves rxIrq at 0, although rxData and rxNinth still update.
- R6: With nineBitMode=0 and filterEn=1, a frame sets rxIrq only when its stop bit is sampled as 1.
- R7: Once set, rxIrq stays at 1 until irqClr is pulsed. One cycle after the pulse it reads 0.
- R8: A low pulse that has ended before the middle of the start bit is treated as a false start. It leaves rxData, rxNinth and rxIrq unchanged, and the receiver accepts the next real frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| nineBitMode | input | 1 | 1: nine bits per frame, 0: eight |
| filterEn | input | 1 | Enables address filtering / stop-bit qualification |
| irqClr | input | 1 | Clears the pending receive interrupt |
| rxData | output | 8 | Last received data byte |
| rxNinth | output | 1 | Ninth bit (or stop bit in eight-bit format) of last frame |
| rxIrq | output | 1 | Pending receive interrupt |

## Verification
A frame's results are set on the ninth sample tick of its stop bit. Counted from the falling edge on rxd, that is two synchroniser cycles plus roughly the frame's bit count times sixteen ticks. The bench holds the line high for two further bit times after each stop bit, so every result is settled before it is sampled. An irqClr pulse applied on a falling clock edge takes effect at the next rising edge, so the cleared flag is checked at the following falling edge. Checks for the false start are made two bit times after the glitch, well after the point where the start would have been rejected.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic voteEn;    // capture an early mid-bit sample
    logic shiftEn;   // push the voted bit into the shift register
    logic finishEn;  // stop bit decided: publish frame, decide interrupt
  } rxStrobe_t;
endpackage

// File: rtl/mpuart_rx_ctrl.sv
module mpuart_rx_ctrl
  import mpuart_pkg::*;
#(
  parameter int TICKS    = 16,
  parameter int MAX_BITS = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxSync,
  input  logic      nineBitMode,
  input  logic      voteBit,
  output rxStrobe_t strb
);
  localparam int CW      = $clog2(TICKS);
  localparam int BW      = $clog2(MAX_BITS + 1);
  localparam int MID     = TICKS / 2;
  localparam int VOTE_LO = MID - 1;
  localparam int VOTE_HI = MID + 1;

  rxState_t       state;
  logic [CW-1:0]  tickCnt;
  logic [BW-1:0]  bitCnt;
  logic [BW-1:0]  lastBit;
  logic           rxPrev;
  logic           fallEdge;
  logic           atDecide;

  assign fallEdge = rxPrev & ~rxSync;
  assign atDecide = sampleTick && (tickCnt == CW'(VOTE_HI));
  assign lastBit  = nineBitMode ? BW'(MAX_BITS - 1) : BW'(MAX_BITS - 2);

  always_comb begin
    strb.voteEn   = sampleTick && (state != ST_IDLE) &&
                    ((tickCnt == CW'(VOTE_LO)) || (tickCnt == CW'(MID)));
    strb.shiftEn  = (state == ST_DATA) && atDecide;
    strb.finishEn = (state == ST_STOP) && atDecide;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      rxPrev  <= 1'b1;
    end else begin
      rxPrev <= rxSync;
      if (state == ST_IDLE) begin
        if (fallEdge) begin
          state   <= ST_START;
          tickCnt <= '0;
        end
      end else begin
        if (sampleTick)
          tickCnt <= (tickCnt == CW'(TICKS - 1)) ? '0 : tickCnt + 1'b1;
        if (atDecide) begin
          unique case (state)
            ST_START: begin
              state  <= voteBit ? ST_IDLE : ST_DATA;
              bitCnt <= '0;
            end
            ST_DATA: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == lastBit) state <= ST_STOP;
            end
            ST_STOP: state <= ST_IDLE;
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R8
  false_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && atDecide && voteBit) |=> (state == ST_IDLE));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftEn, strb.finishEn}));
endmodule

// File: rtl/mpuart_rx_dpath.sv
module mpuart_rx_dpath
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxSync,
  input  logic              nineBitMode,
  input  logic              filterEn,
  input  logic              irqClr,
  input  rxStrobe_t         strb,
  output logic              voteBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxIrq
);
  localparam int SH_W = DATA_W + 1;

  logic [1:0]      early;
  logic [SH_W-1:0] shReg;
  logic            qualBit;
  logic            irqSet;

  // majority of two earlier samples and the current one
  assign voteBit = (early[1] & early[0]) | ((early[1] | early[0]) & rxSync);
  assign qualBit = nineBitMode ? shReg[DATA_W] : voteBit;
  assign irqSet  = strb.finishEn && (!filterEn || qualBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      early   <= '0;
      shReg   <= '0;
      rxData  <= '0;
      rxNinth <= 1'b0;
      rxIrq   <= 1'b0;
    end else begin
      if (strb.voteEn)  early <= {early[0], rxSync};
      if (strb.shiftEn) shReg <= {voteBit, shReg[SH_W-1:1]};
      if (strb.finishEn) begin
        rxData  <= nineBitMode ? shReg[DATA_W-1:0] : shReg[SH_W-1:1];
        rxNinth <= qualBit;
      end
      if (irqSet)      rxIrq <= 1'b1;
      else if (irqClr) rxIrq <= 1'b0;
    end
  end

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq && !irqClr) |=> rxIrq);

  // R5
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishEn && nineBitMode && filterEn && !shReg[DATA_W] && !rxIrq && !irqClr)
      |=> !rxIrq);

  // R6
  stop_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishEn && !nineBitMode && filterEn && !voteBit && !rxIrq && !irqClr)
      |=> !rxIrq);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finishEn |=> $stable(rxData));
endmodule

// File: rtl/mpuart_rx_filter.sv
module mpuart_rx_filter
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxd,
  input  logic              nineBitMode,
  input  logic              filterEn,
  input  logic              irqClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxIrq
);
  logic [1:0] syncFf;
  logic       rxSync;
  logic       voteBit;
  rxStrobe_t  strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncFf <= 2'b11;
    else       syncFf <= {syncFf[0], rxd};
  end
  assign rxSync = syncFf[1];

  mpuart_rx_ctrl #(.TICKS(TICKS), .MAX_BITS(DATA_W + 1)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxSync(rxSync),
    .nineBitMode(nineBitMode), .voteBit(voteBit), .strb(strb)
  );

  mpuart_rx_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .rxSync(rxSync), .nineBitMode(nineBitMode),
    .filterEn(filterEn), .irqClr(irqClr), .strb(strb), .voteBit(voteBit),
    .rxData(rxData), .rxNinth(rxNinth), .rxIrq(rxIrq)
  );
endmodule

// File: tb/sim_mpuart_rx_filter.sv
module sim_mpuart_rx_filter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxd = 1'b1;
  logic       nineBitMode = 1'b0;
  logic       filterEn = 1'b0;
  logic       irqClr = 1'b0;
  logic [7:0] rxData;
  logic       rxNinth;
  logic       rxIrq;

  int checks = 0;
  int failures = 0;
  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks

  always #10 clk = ~clk;  // 50 MHz
  always @(negedge clk) if (rstN) sampleTick <= ~sampleTick;

  mpuart_rx_filter u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxd(rxd),
    .nineBitMode(nineBitMode), .filterEn(filterEn), .irqClr(irqClr),
    .rxData(rxData), .rxNinth(rxNinth), .rxIrq(rxIrq)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic nine, input logic [7:0] b,
                           input logic ninth, input logic stopV);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
    if (nine) sendBit(ninth);
    sendBit(stopV);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic clearIrq();
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    logic [7:0] lastByte;
    logic       lastNinth;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rxData, 8'h00, "R1 data");
    check(rxNinth, 0, "R1 ninth");
    check(rxIrq, 0, "R1 irq");
    rstN = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int n = 0; n < 2; n++)
          for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++) begin
              logic [7:0] b;
              int expNinth, expIrq;
              b = pats[p] ^ 8'(m * 16 + e * 4 + n * 2 + s);
              nineBitMode = m[0];
              filterEn = e[0];
              clearIrq();
              check(rxIrq, 0, "R7 cleared");
              sendFrame(m[0], b, n[0], s[0]);
              expNinth = m ? n : s;
              // R4 no filter, R5 address filter, R6 stop qualification
              expIrq = (e == 0) ? 1 : (m ? n : s);
              check(rxData, b, "R2 data byte");
              check(rxNinth, expNinth, "R3 ninth bit");
              check(rxIrq, expIrq, e == 0 ? "R4 irq" : (m ? "R5 irq" : "R6 irq"));
              if (expIrq == 1) begin
                repeat (3 * BIT_CLKS) @(negedge clk);
                check(rxIrq, 1, "R7 hold");
              end
            end

    // R8 false start: short low pulse, outputs unchanged
    nineBitMode = 1'b1;
    filterEn = 1'b0;
    clearIrq();
    lastByte = rxData;
    lastNinth = rxNinth;
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    check(rxIrq, 0, "R8 irq");
    check(rxData, lastByte, "R8 data");
    check(rxNinth, lastNinth, "R8 ninth");
    sendFrame(1'b1, 8'h96, 1'b1, 1'b1);
    check(rxData, 8'h96, "R8 recovery data");
    check(rxIrq, 1, "R8 recovery irq");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule